// File: doc/BRIEF.md
# Flow-Controlled SPI Slave Byte Port

This block is the serial front end of a command-driven device. A host talks to it over a four-wire SPI link in mode 3 (clock idles high, data captured on the rising clock edge). Each transaction opens with a command byte. While that byte shifts in, the block shifts out an 8-bit status byte. The command byte's most significant bit picks the direction of the data bytes that follow. When it is 1, incoming bytes land in a receive FIFO that the device logic drains. When it is 0, outgoing bytes are taken from a transmit FIFO that the device logic fills.

Both FIFOs hold 32 bytes by default. A ready/busy output paces the host at byte boundaries: it drops when a completed byte leaves the receive FIFO full, or leaves the transmit FIFO empty, during a data phase. It rises again once room or data appears. A host that keeps clocking while busy is shown low is caught in two ways. A status flag records the violation. A sticky interrupt flag, brought out as an open-drain pull-down enable, records any byte that was lost or invented. Reading the status byte clears both flags.

All pin inputs are synchronized into the system clock domain, and edges are detected there. The system clock must therefore run several times faster than the serial clock.

Top module: `spi_buffered_slave`

## Requirements
- R1: After reset, miso_oe is 0, rdy_bsy is 1, irq_od_en is 0, rx_valid is 0 and tx_full is 0.
- R2: miso_oe is 0 while ss_n is high and 1 while ss_n is low, with a delay of only a few system clocks.
- R3: During the command byte, MISO returns a status byte MSB first. It is captured when ss_n falls, with bit 7 power-down input, bit 6 ready (0 after a busy violation), bit 5 interrupt flag, bit 4 receive FIFO full, bit 3 constant 0, bit 2 voice-busy input, bit 1 transmit FIFO full, bit 0 command-busy input.
- R4: MOSI is captured MSB first on SCLK rising edges. When bit 7 of the command byte is 1, each later complete byte is appended to the receive FIFO, and the FIFO presents bytes in arrival order on rx_data/rx_valid/rx_pop.
- R5: When bit 7 of the command byte is 0, each data byte is taken from the transmit FIFO in push order and sent MSB first. Its first bit appears after the first SCLK falling edge of that byte, and later bits follow on later falling edges.
- R6: In a write data phase, rdy_bsy goes low after the byte that fills the receive FIFO. It returns high once a byte is popped. It is high whenever ss_n is high.
- R7: In a read data phase, rdy_bsy is low at a byte boundary while the transmit FIFO is empty, and returns high once a byte is pushed.
- R8: A write data byte that completes while the receive FIFO is full is discarded, and the interrupt flag is set, driving irq_od_en to 1.
- R9: A read data byte started while the transmit FIFO is empty is sent as 0x00, and the interrupt flag is set.
- R10: An SCLK falling edge while rdy_bsy is low makes bit 6 of the next status byte read 0.
- R11: Completing a command byte clears the interrupt flag and the violation flag, so irq_od_en returns to 0.
- R12: A falling ss_n restarts byte framing. A partial byte left by an aborted transaction is dropped and does not shift later bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from host (idles high) |
| ss_n | input | 1 | Active-low slave select |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | Output enable for miso (0 = high impedance) |
| rdy_bsy | output | 1 | 1 = host may clock the next byte, 0 = hold SCLK high |
| irq_od_en | output | 1 | 1 = pull the open-drain interrupt line low |
| pwr_down_in | input | 1 | Power-down state reported in status bit 7 |
| voice_busy_in | input | 1 | Voice-busy state reported in status bit 2 |
| cmd_busy_in | input | 1 | Command-busy state reported in status bit 0 |
| rx_data | output | 8 | Oldest byte in the receive FIFO |
| rx_valid | output | 1 | Receive FIFO not empty |
| rx_pop | input | 1 | Remove the oldest receive byte |
| tx_data | input | 8 | Byte to queue for the host |
| tx_push | input | 1 | Append tx_data to the transmit FIFO |
| tx_full | output | 1 | Transmit FIFO full |

## Verification
The assertions take for granted that each SCLK level and each MOSI value is held for longer than the synchronizer delay plus one system clock. Without that, the rising and falling edges seen inside the block would not match the host's edges one for one. The assertions also assume that SCLK rests high whenever ss_n changes, so that a select edge never coincides with a clock edge. The bench meets both conditions by holding every SCLK phase for ten system clocks. It changes MOSI only together with a falling SCLK, and moves ss_n only after a full half period with SCLK high.

// File: rtl/spi_buf_pkg.sv
package spi_buf_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // Bit order of this struct is the on-wire status order, MSB first.
  typedef struct packed {
    logic pwr_down;
    logic ready;
    logic irq;
    logic rx_full;
    logic spare;
    logic voice_busy;
    logic tx_full;
    logic cmd_busy;
  } stat_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_VAL;
        else     chain[g] <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_VAL;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             pop,
  output logic [WIDTH-1:0] rd_data,
  output logic             full,
  output logic             empty
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [AW:0]      count;
  logic             push_ok, pop_ok;

  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  // Storage without reset so it can map onto RAM resources.
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rd_data = mem[rd_ptr];
  assign full    = (count == FULL_CNT);
  assign empty   = (count == '0);

  // Pushing into a full FIFO leaves its fill level unchanged.
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> (count == FULL_CNT));

  // Popping an empty FIFO leaves it empty.
  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> (count == '0));
endmodule

// File: rtl/spi_frame_ctl.sv
module spi_frame_ctl
  import spi_buf_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  sclk_s,
  input  logic  ss_s,
  input  logic  mosi_s,
  input  logic  pwr_down_in,
  input  logic  voice_busy_in,
  input  logic  cmd_busy_in,
  input  logic  rx_full,
  input  logic  tx_empty,
  input  logic  tx_full,
  input  byte_t tx_rd_data,
  output logic  rx_push,
  output byte_t rx_wr_data,
  output logic  tx_pop,
  output logic  miso,
  output logic  miso_oe,
  output logic  rdy_bsy,
  output logic  irq_od_en
);
  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST_BIT = CW'(BYTE_W - 1);

  logic          sclk_d, ss_d;
  logic [CW-1:0] bit_cnt;
  logic          in_cmd, dir_wr, byte_open;
  byte_t         sh_in, sh_out, stat_snap;
  logic          miso_q, oe_q, rdy_q, irq_flag, viol_flag;

  logic  active, ss_fall, rise, fall, byte_done, data_phase, boundary, lead_fall;
  byte_t rx_byte, next_byte;
  stat_t cur_stat;

  assign active     = !ss_s;
  assign ss_fall    = ss_d && !ss_s;
  assign rise       = active && sclk_s && !sclk_d;
  assign fall       = active && !sclk_s && sclk_d;
  assign byte_done  = rise && (bit_cnt == LAST_BIT);
  assign data_phase = active && !in_cmd;
  assign boundary   = data_phase && !byte_open;
  assign lead_fall  = fall && !byte_open;
  assign rx_byte    = {sh_in[BYTE_W-2:0], mosi_s};

  always_comb begin
    cur_stat            = '0;
    cur_stat.pwr_down   = pwr_down_in;
    cur_stat.ready      = !viol_flag;
    cur_stat.irq        = irq_flag;
    cur_stat.rx_full    = rx_full;
    cur_stat.voice_busy = voice_busy_in;
    cur_stat.tx_full    = tx_full;
    cur_stat.cmd_busy   = cmd_busy_in;
  end

  always_comb begin
    if (in_cmd)                 next_byte = stat_snap;
    else if (dir_wr || tx_empty) next_byte = '0;
    else                         next_byte = tx_rd_data;
  end

  assign tx_pop     = lead_fall && data_phase && !dir_wr && !tx_empty;
  assign rx_push    = byte_done && !in_cmd && dir_wr && !rx_full;
  assign rx_wr_data = rx_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d    <= 1'b1;
      ss_d      <= 1'b1;
      bit_cnt   <= '0;
      in_cmd    <= 1'b1;
      dir_wr    <= 1'b0;
      byte_open <= 1'b0;
      sh_in     <= '0;
      sh_out    <= '0;
      stat_snap <= '0;
      miso_q    <= 1'b0;
      oe_q      <= 1'b0;
      rdy_q     <= 1'b1;
      irq_flag  <= 1'b0;
      viol_flag <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      ss_d   <= ss_s;
      oe_q   <= active;
      rdy_q  <= !(boundary && (dir_wr ? rx_full : tx_empty));
      if (ss_fall) begin
        bit_cnt   <= '0;
        in_cmd    <= 1'b1;
        byte_open <= 1'b0;
        stat_snap <= byte_t'(cur_stat);
        miso_q    <= cur_stat.pwr_down;
      end else if (!active) begin
        in_cmd    <= 1'b1;
        byte_open <= 1'b0;
      end else if (fall) begin
        if (!byte_open) begin
          byte_open <= 1'b1;
          miso_q    <= next_byte[BYTE_W-1];
          sh_out    <= {next_byte[BYTE_W-2:0], 1'b0};
          if (data_phase && !dir_wr && tx_empty) irq_flag <= 1'b1;
        end else begin
          miso_q <= sh_out[BYTE_W-1];
          sh_out <= {sh_out[BYTE_W-2:0], 1'b0};
        end
        if (!rdy_q) viol_flag <= 1'b1;
      end else if (rise) begin
        sh_in   <= rx_byte;
        bit_cnt <= bit_cnt + 1'b1;
        if (byte_done) begin
          byte_open <= 1'b0;
          if (in_cmd) begin
            in_cmd    <= 1'b0;
            dir_wr    <= rx_byte[BYTE_W-1];
            irq_flag  <= 1'b0;
            viol_flag <= 1'b0;
          end else if (dir_wr && rx_full) begin
            irq_flag <= 1'b1;
          end
        end
      end
    end
  end

  assign miso      = miso_q;
  assign miso_oe   = oe_q;
  assign rdy_bsy   = rdy_q;
  assign irq_od_en = irq_flag;

  assert_hiz_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (ss_s && ss_d) |-> !miso_oe);

  assert_ready_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (ss_s && ss_d) |=> rdy_bsy);

  assert_overrun_irq_R8: assert property (@(posedge clk) disable iff (rst)
    (byte_done && !in_cmd && dir_wr && rx_full) |=> irq_od_en);

  assert_empty_read_R9: assert property (@(posedge clk) disable iff (rst)
    (lead_fall && data_phase && !dir_wr && tx_empty) |=> (irq_od_en && !miso));

  assert_busy_violation_R10: assert property (@(posedge clk) disable iff (rst)
    (fall && !rdy_bsy) |=> viol_flag);

  assert_status_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (byte_done && in_cmd) |=> (!irq_od_en && !viol_flag));
endmodule

// File: rtl/spi_buffered_slave.sv
module spi_buffered_slave
  import spi_buf_pkg::*;
#(
  parameter int FIFO_DEPTH  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sclk,
  input  logic        ss_n,
  input  logic        mosi,
  output logic        miso,
  output logic        miso_oe,
  output logic        rdy_bsy,
  output logic        irq_od_en,
  input  logic        pwr_down_in,
  input  logic        voice_busy_in,
  input  logic        cmd_busy_in,
  output logic [7:0]  rx_data,
  output logic        rx_valid,
  input  logic        rx_pop,
  input  logic [7:0]  tx_data,
  input  logic        tx_push,
  output logic        tx_full
);
  logic [2:0] pins_s;
  logic       rx_push, rx_full, rx_empty, tx_pop, tx_empty;
  byte_t      rx_wr_data, tx_rd_data;

  // Order {ss_n, sclk, mosi}; select and clock idle high.
  spi_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst(rst), .d_in({ss_n, sclk, mosi}), .d_out(pins_s)
  );

  spi_frame_ctl u_frame (
    .clk(clk), .rst(rst),
    .sclk_s(pins_s[1]), .ss_s(pins_s[2]), .mosi_s(pins_s[0]),
    .pwr_down_in(pwr_down_in), .voice_busy_in(voice_busy_in), .cmd_busy_in(cmd_busy_in),
    .rx_full(rx_full), .tx_empty(tx_empty), .tx_full(tx_full), .tx_rd_data(tx_rd_data),
    .rx_push(rx_push), .rx_wr_data(rx_wr_data), .tx_pop(tx_pop),
    .miso(miso), .miso_oe(miso_oe), .rdy_bsy(rdy_bsy), .irq_od_en(irq_od_en)
  );

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) u_rx_fifo (
    .clk(clk), .rst(rst), .push(rx_push), .wr_data(rx_wr_data), .pop(rx_pop),
    .rd_data(rx_data), .full(rx_full), .empty(rx_empty)
  );

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) u_tx_fifo (
    .clk(clk), .rst(rst), .push(tx_push), .wr_data(tx_data), .pop(tx_pop),
    .rd_data(tx_rd_data), .full(tx_full), .empty(tx_empty)
  );

  assign rx_valid = !rx_empty;
endmodule

// File: tb/spi_buffered_slave_test.sv
module spi_buffered_slave_test;
  localparam int HP = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, sclk, ss_n, mosi, miso, miso_oe, rdy_bsy, irq_od_en;
  logic pwr_down_in, voice_busy_in, cmd_busy_in;
  logic [7:0] rx_data, tx_data;
  logic rx_valid, rx_pop, tx_push, tx_full;
  int errs = 0;
  int checks = 0;
  bit done = 0;

  spi_buffered_slave uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_c(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ss_begin();
    @(negedge clk) ss_n = 1'b0;
    wait_c(HP);
  endtask

  task automatic ss_end();
    wait_c(HP);
    ss_n = 1'b1;
    wait_c(HP);
  endtask

  task automatic xfer(input logic [7:0] o, output logic [7:0] i, input int nbits = 8);
    i = '0;
    for (int b = 7; b > 7 - nbits; b--) begin
      @(negedge clk);
      sclk = 1'b0;
      mosi = o[b];
      wait_c(HP);
      i[b] = miso;
      sclk = 1'b1;
      wait_c(HP);
    end
  endtask

  task automatic rx_get(output logic [7:0] d, output logic v);
    @(negedge clk);
    v = rx_valid;
    d = rx_data;
    if (v) rx_pop = 1'b1;
    @(negedge clk) rx_pop = 1'b0;
  endtask

  task automatic tx_put(input logic [7:0] d);
    @(negedge clk);
    tx_data = d;
    tx_push = 1'b1;
    @(negedge clk) tx_push = 1'b0;
  endtask

  task automatic status_txn(output logic [7:0] s);
    ss_begin();
    xfer(8'h80, s);
    ss_end();
  endtask

  task automatic t_reset();
    chk("R1 miso_oe", miso_oe, 0);
    chk("R1 rdy_bsy", rdy_bsy, 1);
    chk("R1 irq_od_en", irq_od_en, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 tx_full", tx_full, 0);
  endtask

  task automatic t_status();
    logic [7:0] s;
    pwr_down_in = 1'b1; cmd_busy_in = 1'b1;
    ss_begin();
    chk("R2 oe while selected", miso_oe, 1);
    xfer(8'h80, s);
    ss_end();
    chk("R2 oe after deselect", miso_oe, 0);
    chk("R3 status pd+cbusy", s, 8'hC1);
    pwr_down_in = 1'b0; cmd_busy_in = 1'b0; voice_busy_in = 1'b1;
    status_txn(s);
    chk("R3 status vbusy", s, 8'h44);
    voice_busy_in = 1'b0;
  endtask

  task automatic t_write();
    logic [7:0] s, d;
    logic v;
    ss_begin();
    xfer(8'h80, s);
    xfer(8'h3C, s);
    xfer(8'hA5, s);
    xfer(8'h01, s);
    ss_end();
    rx_get(d, v); chk("R4 byte0", d, 8'h3C);
    rx_get(d, v); chk("R4 byte1", d, 8'hA5);
    rx_get(d, v); chk("R4 byte2", d, 8'h01);
    chk("R4 rx drained", rx_valid, 0);
  endtask

  task automatic t_read();
    logic [7:0] s, d;
    tx_put(8'h5A);
    tx_put(8'hC3);
    ss_begin();
    xfer(8'h00, s);
    xfer(8'h00, d); chk("R5 read byte0", d, 8'h5A);
    xfer(8'h00, d); chk("R5 read byte1", d, 8'hC3);
    ss_end();
    chk("R5 no irq", irq_od_en, 0);
  endtask

  task automatic t_write_full();
    logic [7:0] s, d;
    logic v;
    bit bad;
    ss_begin();
    xfer(8'h81, s);
    for (int k = 0; k < 32; k++) begin
      xfer(8'(k * 3 + 5), s);
      if (k == 30) chk("R6 ready before full", rdy_bsy, 1);
    end
    chk("R6 busy when full", rdy_bsy, 0);
    rx_get(d, v);
    chk("R6 popped first", d, 8'h05);
    wait_c(5);
    chk("R6 ready after pop", rdy_bsy, 1);
    xfer(8'hEE, s);
    chk("R6 busy refilled", rdy_bsy, 0);
    xfer(8'hDD, s);
    chk("R8 irq on overrun", irq_od_en, 1);
    ss_end();
    chk("R6 ready when idle", rdy_bsy, 1);
    status_txn(s);
    chk("R10 status after violation", s, 8'h30);
    chk("R11 irq cleared", irq_od_en, 0);
    bad = 0;
    for (int k = 1; k < 32; k++) begin
      rx_get(d, v);
      if (!v || d != 8'(k * 3 + 5)) bad = 1;
    end
    chk("R8 kept bytes intact", bad, 0);
    rx_get(d, v);
    chk("R8 last kept byte", d, 8'hEE);
    chk("R8 overrun byte dropped", rx_valid, 0);
    status_txn(s);
    chk("R11 status clean", s, 8'h40);
  endtask

  task automatic t_read_empty();
    logic [7:0] s, d;
    ss_begin();
    xfer(8'h00, s);
    wait_c(4);
    chk("R7 busy on empty", rdy_bsy, 0);
    tx_put(8'h99);
    wait_c(4);
    chk("R7 ready after push", rdy_bsy, 1);
    xfer(8'h00, d);
    chk("R5 read pushed byte", d, 8'h99);
    chk("R7 busy drained", rdy_bsy, 0);
    xfer(8'h00, d);
    chk("R9 zero on empty", d, 8'h00);
    chk("R9 irq on empty", irq_od_en, 1);
    ss_end();
    status_txn(s);
    chk("R10 status after empty read", s, 8'h20);
    chk("R11 irq released", irq_od_en, 0);
  endtask

  task automatic t_partial();
    logic [7:0] s, d;
    logic v;
    ss_begin();
    xfer(8'h80, s);
    xfer(8'h11, s);
    xfer(8'hF0, s, 5);
    ss_end();
    ss_begin();
    xfer(8'h80, s);
    xfer(8'h22, s);
    ss_end();
    rx_get(d, v); chk("R12 first byte", d, 8'h11);
    rx_get(d, v); chk("R12 aligned byte", d, 8'h22);
    chk("R12 partial dropped", rx_valid, 0);
  endtask

  initial begin
    rst = 1'b1; sclk = 1'b1; ss_n = 1'b1; mosi = 1'b1;
    pwr_down_in = 1'b0; voice_busy_in = 1'b0; cmd_busy_in = 1'b0;
    rx_pop = 1'b0; tx_push = 1'b0; tx_data = '0;
    wait_c(5);
    rst = 1'b0;
    wait_c(4);
    t_reset();
    t_status();
    t_write();
    t_read();
    t_write_full();
    t_read_empty();
    t_partial();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule